// File: doc/BRIEF.md
# Paged External Data RAM

This block is a 512-byte data RAM placed in a processor's 64K external data space. The processor reaches it with external move transactions, and those transactions go to this RAM unless something outside the block routes them elsewhere. There are two ways to form an address:

- **16-bit pointer mode:** a 16-bit pointer supplies the whole address. Only the low nine bits pick a byte, so the RAM repeats every 0x200 bytes across the 64K space. A linear fill can therefore run past the top of the RAM without reloading the pointer.
- **8-bit operand mode:** an 8-bit operand gives the low address byte. A one-bit page register gives the high part.

Software reads and writes the page register through a small special-function-register port at address 0xAA.

Requests arrive on a valid/ready channel. A write is complete once it is accepted and returns nothing. An accepted read returns one byte on a response channel with valid/ready. The response register is one entry deep. While a response waits with its ready low, the block drops request ready, so no new request is taken until the response is consumed.

Top module: `paged_xram`

## Requirements
- R1: In 16-bit pointer mode (`req_mode`=0), the byte index is `req_ptr[8:0]`. Pointer bits 15..9 are ignored, so addresses that differ only by multiples of 0x200 reach the same byte.
- R2: In 8-bit operand mode (`req_mode`=1), the byte index is {page bit, `req_opnd`}. With the page at 1, operands 0x00..0xFF reach bytes 0x100..0x1FF. With the page at 0, they reach bytes 0x000..0x0FF.
- R3: `sfr_rdata` shows {7'b0, page bit} in the same cycle that `sfr_addr` is 0xAA, and 0x00 for any other address.
- R4: A write to 0xAA stores only bit 0 of the data, and bits 7..1 always read as zero. A write to any other SFR address leaves the page unchanged.
- R5: A page write is used by every access accepted after its clock edge. An access accepted on the same edge as the page write uses the old page.
- R6: A read accepted on a clock edge raises `rsp_valid` on that edge, and `rsp_data` carries the addressed byte.
- R7: `req_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold their values.
- R8: An accepted write stores `req_wdata` at the formed index and produces no response.
- R9: After reset, `rsp_valid` is 0 and the page is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 1 | 0 = 16-bit pointer, 1 = 8-bit operand with page |
| req_ptr | input | 16 | Pointer address |
| req_opnd | input | 8 | 8-bit operand address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 8 | Read data |
| sfr_addr | input | 8 | SFR address |
| sfr_we | input | 1 | SFR write enable |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for `sfr_addr` |

## Verification
Each result has a fixed due time:
- `sfr_rdata` and `req_ready` are combinational and are due in the same cycle as their inputs.
- A page write shows up on `sfr_rdata`, and is used for address forming, from the next edge onward.
- Read data is due one edge after acceptance and stays put for as long as `rsp_ready` is held low.

The bench drives its inputs just after the rising edge and compares every output at the falling edge against a behavioural model that advances on each rising edge. Each result is therefore checked in exactly the cycle it is due.

// File: rtl/xram_pkg.sv
`timescale 1ns/1ps
package xram_pkg;
  // address-forming modes
  typedef enum logic {
    MODE_PTR16 = 1'b0,
    MODE_OPND8 = 1'b1
  } xmode_e;

  localparam int unsigned DEF_ADDR_W    = 16;
  localparam int unsigned DEF_DATA_W    = 8;
  localparam int unsigned DEF_OPND_W    = 8;
  localparam int unsigned DEF_RAM_BYTES = 512;
  localparam logic [7:0]  DEF_PAGE_SFR  = 8'hAA;
endpackage

// File: rtl/xram_page_reg.sv
`timescale 1ns/1ps
module xram_page_reg #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PAGE_W   = 1,
  parameter logic [7:0]  SFR_ADDR = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        sfr_addr,
  input  logic              sfr_we,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [PAGE_W-1:0] page_q,
  output logic [DATA_W-1:0] sfr_rdata
);
  localparam int unsigned PAD_W = DATA_W - PAGE_W;

  logic hit;
  logic unused_wdata_hi;

  assign hit             = (sfr_addr == SFR_ADDR);
  assign unused_wdata_hi = ^sfr_wdata[DATA_W-1:PAGE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      page_q <= '0;
    else if (sfr_we && hit)
      page_q <= sfr_wdata[PAGE_W-1:0];
  end

  always_comb begin
    sfr_rdata = '0;
    if (hit)
      sfr_rdata = {{PAD_W{1'b0}}, page_q};
  end
endmodule

// File: rtl/xram_addr_gen.sv
`timescale 1ns/1ps
module xram_addr_gen
  import xram_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OPND_W = 8,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned PAGE_W = 1
) (
  input  xmode_e            mode,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [OPND_W-1:0] opnd,
  input  logic [PAGE_W-1:0] page,
  output logic [IDX_W-1:0]  idx
);
  logic [IDX_W-1:0] idx_ptr;
  logic [IDX_W-1:0] idx_opnd;
  logic             unused_ptr_hi;

  // upper pointer bits do not take part: the RAM aliases modulo its size
  assign idx_ptr       = ptr[IDX_W-1:0];
  assign unused_ptr_hi = ^ptr[ADDR_W-1:IDX_W];

  generate
    if (IDX_W > OPND_W) begin : g_paged
      assign idx_opnd = {page, opnd};
    end else begin : g_flat
      logic unused_page;
      assign unused_page = ^page;
      assign idx_opnd    = opnd[IDX_W-1:0];
    end
  endgenerate

  assign idx = (mode == MODE_OPND8) ? idx_opnd : idx_ptr;
endmodule

// File: rtl/xram_array.sv
`timescale 1ns/1ps
module xram_array #(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (acc_en && acc_we)
      mem[idx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (acc_en && !acc_we) begin
      rsp_valid <= 1'b1;
      rsp_data  <= mem[idx];
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/paged_xram.sv
`timescale 1ns/1ps
module paged_xram
  import xram_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned OPND_W    = DEF_OPND_W,
  parameter int unsigned RAM_BYTES = DEF_RAM_BYTES,
  parameter logic [7:0]  SFR_ADDR  = DEF_PAGE_SFR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_mode,
  input  logic [ADDR_W-1:0] req_ptr,
  input  logic [OPND_W-1:0] req_opnd,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [7:0]        sfr_addr,
  input  logic              sfr_we,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata
);
  localparam int unsigned IDX_W  = $clog2(RAM_BYTES);
  localparam int unsigned PAGE_W = (IDX_W > OPND_W) ? (IDX_W - OPND_W) : 1;

  logic [PAGE_W-1:0] page_q;
  logic [IDX_W-1:0]  idx;
  logic              acc_en;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc_en    = req_valid && req_ready;

  xram_page_reg #(
    .DATA_W   (DATA_W),
    .PAGE_W   (PAGE_W),
    .SFR_ADDR (SFR_ADDR)
  ) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfr_addr  (sfr_addr),
    .sfr_we    (sfr_we),
    .sfr_wdata (sfr_wdata),
    .page_q    (page_q),
    .sfr_rdata (sfr_rdata)
  );

  xram_addr_gen #(
    .ADDR_W (ADDR_W),
    .OPND_W (OPND_W),
    .IDX_W  (IDX_W),
    .PAGE_W (PAGE_W)
  ) u_agen (
    .mode (xmode_e'(req_mode)),
    .ptr  (req_ptr),
    .opnd (req_opnd),
    .page (page_q),
    .idx  (idx)
  );

  xram_array #(
    .DEPTH  (RAM_BYTES),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .acc_we    (req_write),
    .idx       (idx),
    .wdata     (req_wdata),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/xram_chk.sv
`timescale 1ns/1ps
module xram_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PAGE_W   = 1,
  parameter logic [7:0]  SFR_ADDR = 8'hAA
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [7:0]        sfr_addr,
  input logic              sfr_we,
  input logic [DATA_W-1:0] sfr_wdata,
  input logic [DATA_W-1:0] sfr_rdata,
  input logic [PAGE_W-1:0] page_q
);
  // R7: a stalled response keeps its valid and data
  a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R7: no request is taken while a response is stalled
  a_r7_no_accept_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R6: an accepted read raises the response on the next edge
  a_r6_read_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  // R8: an accepted write leaves no response behind
  a_r8_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !rsp_valid);

  // R3: the unimplemented upper bits never read as one
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_rdata[DATA_W-1:PAGE_W] == '0);

  // R5: a page write is in place after its edge
  a_r5_page_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && sfr_addr == SFR_ADDR) |=> (page_q == $past(sfr_wdata[PAGE_W-1:0])));

  // R4: writes elsewhere, or no write, leave the page alone
  a_r4_page_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !(sfr_we && sfr_addr == SFR_ADDR) |=> $stable(page_q));
endmodule

bind paged_xram xram_chk #(
  .DATA_W   (DATA_W),
  .PAGE_W   (PAGE_W),
  .SFR_ADDR (SFR_ADDR)
) u_chk (.*);

// File: tb/paged_xram_test.sv
`timescale 1ns/1ps
module paged_xram_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_mode = 1'b0;
  logic [15:0] req_ptr = '0;
  logic [7:0]  req_opnd = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic [7:0]  sfr_addr = '0;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_wdata = '0;
  logic [7:0]  sfr_rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit bp_on = 1'b0;

  // model state
  logic [7:0] m_mem [512];
  bit         m_known [512];
  bit         m_rv = 1'b0;
  logic [7:0] m_rd = '0;
  bit         m_rd_known = 1'b0;
  int         m_page = 0;

  always #10 clk = ~clk;

  paged_xram uut (.*);

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int fillv(input int a);
    return (a * 5 + 3) & 8'hFF;
  endfunction

  // content left by the linear fill of 0x000..0x2FF
  function automatic int filled(input int i);
    return (i < 'h100) ? fillv(i + 'h200) : fillv(i);
  endfunction

  // reference model, advances on every rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      bit acc;
      int ix;
      cyc++;
      acc = req_valid && (!m_rv || rsp_ready);
      if (m_rv && rsp_ready) m_rv = 1'b0;
      if (acc) begin
        ix = req_mode ? ((m_page << 8) | req_opnd) : (req_ptr & 'h1FF);
        if (req_write) begin
          m_mem[ix] = req_wdata;
          m_known[ix] = 1'b1;
        end else begin
          m_rv = 1'b1;
          m_rd = m_mem[ix];
          m_rd_known = m_known[ix];
        end
      end
      if (sfr_we && sfr_addr == 8'hAA) m_page = sfr_wdata[0];
    end
  end

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready == (!m_rv || rsp_ready), "R7 req_ready", req_ready, !m_rv || rsp_ready);
      chk(rsp_valid == m_rv, "R6/R8 rsp_valid", rsp_valid, m_rv);
      if (m_rv && m_rd_known)
        chk(rsp_data == m_rd, "R1/R2 rsp_data", rsp_data, m_rd);
      chk(sfr_rdata == ((sfr_addr == 8'hAA) ? m_page : 0), "R3 sfr_rdata",
          sfr_rdata, (sfr_addr == 8'hAA) ? m_page : 0);
    end
  end

  // back-pressure pattern on the response
  always @(posedge clk) begin
    #2;
    rsp_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
  end

  task automatic access(input bit mode, input int ptr, input int op,
                        input bit wr, input int wd);
    bit rdy;
    @(posedge clk); #2;
    req_valid = 1'b1; req_mode = mode; req_ptr = ptr[15:0];
    req_opnd = op[7:0]; req_write = wr; req_wdata = wd[7:0];
    do begin
      @(negedge clk);
      rdy = req_ready;
      @(posedge clk); #2;
    end while (!rdy);
    req_valid = 1'b0;
  endtask

  task automatic rd_expect(input bit mode, input int ptr, input int op,
                           input int exp, input string tag);
    access(mode, ptr, op, 1'b0, 0);
    do @(negedge clk); while (!(rsp_valid && rsp_ready));
    chk(rsp_data == exp[7:0], tag, rsp_data, exp);
  endtask

  task automatic sfr_write(input int a, input int d);
    @(posedge clk); #2;
    sfr_we = 1'b1; sfr_addr = a[7:0]; sfr_wdata = d[7:0];
    @(posedge clk); #2;
    sfr_we = 1'b0; sfr_addr = 8'hAA;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit rdy;
    repeat (3) @(posedge clk);
    sfr_addr = 8'hAA;
    #1;
    chk(rsp_valid == 1'b0, "R9 rsp_valid after reset", rsp_valid, 0);
    chk(sfr_rdata == 8'h00, "R9 page after reset", sfr_rdata, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 R8: linear fill through 16-bit pointers past the top of the RAM
    for (int a = 0; a < 'h300; a++) access(1'b0, a, 0, 1'b1, fillv(a));

    // R1: aliasing across the whole space
    rd_expect(1'b0, 'h0000, 0, filled('h000), "R1 ptr 0x0000");
    rd_expect(1'b0, 'h0200, 0, filled('h000), "R1 ptr 0x0200");
    rd_expect(1'b0, 'hFE05, 0, filled('h005), "R1 ptr 0xFE05");
    rd_expect(1'b0, 'h01FF, 0, filled('h1FF), "R1 ptr 0x01FF");
    rd_expect(1'b0, 'h7F80, 0, filled('h180), "R1 ptr 0x7F80");

    // R2: operand mode against both page values
    rd_expect(1'b1, 0, 'h34, filled('h034), "R2 page0 op 0x34");
    sfr_write('hAA, 'h01);
    rd_expect(1'b1, 0, 'h34, filled('h134), "R2 page1 op 0x34");
    rd_expect(1'b1, 0, 'hFF, filled('h1FF), "R2 page1 op 0xFF");
    access(1'b1, 0, 'h22, 1'b1, 'h5A);
    rd_expect(1'b0, 'hC322, 0, 'h5A, "R2 R8 page1 write seen at ptr alias");

    // R4: only bit 0 is stored, other addresses ignored
    sfr_write('hAA, 'hFE);
    @(negedge clk);
    chk(sfr_rdata == 8'h00, "R4 write 0xFE reads 0", sfr_rdata, 0);
    sfr_write('hAA, 'hFF);
    @(negedge clk);
    chk(sfr_rdata == 8'h01, "R4 write 0xFF reads 1", sfr_rdata, 1);
    sfr_write('hAB, 'h00);
    @(negedge clk);
    chk(sfr_rdata == 8'h01, "R4 other address leaves page", sfr_rdata, 1);
    sfr_addr = 8'hAB;
    @(negedge clk);
    chk(sfr_rdata == 8'h00, "R3 non-page address reads 0", sfr_rdata, 0);
    sfr_addr = 8'hAA;
    rd_expect(1'b1, 0, 'h40, filled('h140), "R4 page still 1 for access");

    // R5: same-edge page write uses the old page, next access the new one
    @(posedge clk); #2;
    sfr_we = 1'b1; sfr_addr = 8'hAA; sfr_wdata = 8'h00;
    req_valid = 1'b1; req_mode = 1'b1; req_opnd = 8'h10; req_write = 1'b0;
    @(negedge clk); rdy = req_ready;
    chk(rdy, "R5 request taken with page write", rdy, 1);
    @(posedge clk); #2;
    sfr_we = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_data == filled('h110), "R5 same-edge access uses old page", rsp_data, filled('h110));
    rd_expect(1'b1, 0, 'h10, filled('h010), "R5 next access uses new page");

    // R7: reads under back-pressure
    bp_on = 1'b1;
    for (int k = 0; k < 40; k++)
      rd_expect(1'b0, k * 'h0213, 0, filled((k * 'h213) & 'h1FF), "R7 read under back-pressure");
    bp_on = 1'b0;
    repeat (4) @(posedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule